// File: doc/BRIEF.md
# Per-Chip-Select SPI Master Engine

This block is the serial shifting core of an SPI master. It drives four chip-select lines and keeps a separate mode word for each of them. The mode word for the addressed chip select sets three things: the idle level of the serial clock, which clock edge captures data, and the order in which bits go out. A small write/read port lets a register bus program the four mode words and read them back.

A transfer begins with a one-cycle start pulse. The pulse carries a chip-select index, a data character and a character length. At that point the engine copies the selected mode word, so a later write to that word cannot change a transfer that is already running. A separate baud generator supplies a clock-enable tick. Each tick produces one half-period of the serial clock. The engine asserts the chip select before the first clock edge and releases it one tick after the last edge. It then gives a single-cycle done pulse, with the received character right-aligned.

Top module: `spi_cs_master`

## Requirements
- R1: Each of the four mode words resets to zero. A write (`cfg_we` high at a clock edge) replaces the word at `cfg_addr` with `cfg_wdata`, and `cfg_rdata` shows the word at `cfg_addr` combinationally. The field layout is: bit 0 = clock invert, bit 1 = clock phase, bit 2 = MSB-first request.
- R2: Whenever no chip select is asserted, `sck` sits at the clock-invert value of the mode word captured at the last accepted start, and it does not toggle. That value is 0 after reset.
- R3: A start pulse received while idle is accepted. In the next cycle exactly `cs_n[cs_idx]` goes low and the other chip selects stay high. It stays low until the release described in R4.
- R4: While the chip select is asserted, each tick toggles `sck` once, and only a tick can toggle it. A transfer of length L has exactly 2L toggles. The first toggle comes on the first tick after acceptance. The chip select is released on the tick after the last toggle.
- R5: With clock phase 0, each bit is on `mosi` from the start of its period, and the 1st, 3rd, 5th... toggles capture it. With clock phase 1, `mosi` advances on the 1st, 3rd... toggles, and the 2nd, 4th... toggles capture. `miso` is sampled on the capturing toggles.
- R6: By default bits go out least significant first. When the MSB-first bit is set and the length is 8 or 16, they go out most significant first. For any other length with that bit set, the order stays least significant first.
- R7: Supported lengths are 4 to 16. `rx_data` holds the received character right-aligned. Each bit i is the `miso` value captured for character bit i, and bits at or above the length read as zero.
- R8: `done` is high for exactly one cycle, which is the first cycle in which all chip selects are high again after a transfer.
- R9: A start pulse received while a transfer is in progress is ignored. The chip selects, the serial stream and the received character of the running transfer are unaffected.
- R10: A mode write during a transfer takes effect in the mode word at once (R1), but the running transfer keeps the polarity, phase and order it captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_addr | input | 2 | Mode word index for write and read |
| cfg_wdata | input | 3 | Mode word write data (bit0 invert, bit1 phase, bit2 MSB-first) |
| cfg_rdata | output | 3 | Mode word at `cfg_addr` |
| start | input | 1 | Transfer request pulse |
| cs_idx | input | 2 | Chip select to use for the transfer |
| tx_data | input | 16 | Character to send, right-aligned |
| char_len | input | 5 | Character length in bits, 4 to 16 |
| tick | input | 1 | Half-period enable from the baud generator |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 4 | Active-low chip selects |
| rx_data | output | 16 | Received character, right-aligned |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Read-back of a mode word is combinational, so it is checked one half-cycle after the writing edge. The chip select and the captured idle level are registered once from the start pulse and are checked at the falling edge that follows the accepting rising edge. Each `sck` toggle shows up one register after its tick. The bench monitor therefore compares `sck` at every falling edge while the chip select is held, counts the toggles, and records `mosi` after each capturing toggle. It loops `miso` back as the inverse of `mosi`. `done`, the release of the chip select and `rx_data` are all due 2L+1 ticks after acceptance and are checked in the cycle where `done` is first seen. The pulse ending is checked one cycle later.

// File: rtl/spi_cs_pkg.sv
// Package: shared types of the per-chip-select SPI master.
// Assumes: mode word layout bit0 invert, bit1 phase, bit2 MSB-first.
package spi_cs_pkg;

    localparam int MODE_W = 3;

    typedef struct packed {
        logic msb_first;
        logic phase;
        logic invert;
    } spi_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } eng_state_t;

endpackage

// File: rtl/spi_mode_bank.sv
// Module: bank of per-chip-select mode words with one write port and two
// combinational read ports (register bus and engine).
// Assumes: NUM_CS is a power of two so every address selects a word.
module spi_mode_bank
    import spi_cs_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CS_W   = $clog2(NUM_CS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CS_W-1:0] wr_addr,
    input  spi_mode_t       wr_mode,
    input  logic [CS_W-1:0] rd_addr,
    output spi_mode_t       rd_mode,
    input  logic [CS_W-1:0] sel_addr,
    output spi_mode_t       sel_mode
);

    spi_mode_t bank [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_word
        // Holds one mode word; cleared by reset, replaced on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (wr_en && wr_addr == CS_W'(g)) begin
                bank[g] <= wr_mode;
            end
        end
    end

    // Register bus read and engine selection are plain lookups.
    assign rd_mode  = bank[rd_addr];
    assign sel_mode = bank[sel_addr];

    // R1: a write is visible at its address in the following cycle.
    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en) |=> (bank[$past(wr_addr)] == $past(wr_mode)));

endmodule

// File: rtl/spi_shift_engine.sv
// Module: tick-paced SPI shift engine. Captures the selected mode word,
// length, chip select and character on an accepted start, then makes one
// serial-clock half-period per tick.
// Assumes: char_len within 4..MAX_LEN; tick is a one-cycle enable.
module spi_shift_engine
    import spi_cs_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int MAX_LEN = 16,
    parameter int CS_W    = $clog2(NUM_CS),
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CS_W-1:0]    cs_sel,
    input  spi_mode_t          mode_sel,
    input  logic [MAX_LEN-1:0] tx_data,
    input  logic [LEN_W-1:0]   char_len,
    input  logic               tick,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic [NUM_CS-1:0]  cs_n,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               done
);

    localparam int EC_W = LEN_W + 1;

    eng_state_t         state_q;
    spi_mode_t          mode_q;
    logic [LEN_W-1:0]   len_q;
    logic [CS_W-1:0]    cs_q;
    logic [MAX_LEN-1:0] tx_q;
    logic [MAX_LEN-1:0] rx_q;
    logic [EC_W-1:0]    ec_q;
    logic               tgl_q;
    logic               rev_q;

    logic [EC_W-1:0]    ec_m1;
    logic [EC_W-1:0]    ec_end;
    logic [LEN_W-1:0]   k_out;
    logic [LEN_W-1:0]   k_smp;
    logic [LEN_W-1:0]   p_out;
    logic [LEN_W-1:0]   p_smp;
    logic               bit_out;
    logic               running;

    // Maps a transfer-order bit number to a character bit position.
    function automatic logic [LEN_W-1:0] phys_pos(input logic [LEN_W-1:0] k,
                                                  input logic [LEN_W-1:0] len,
                                                  input logic rev);
        return rev ? (len - k - LEN_W'(1)) : k;
    endfunction

    // Works out which bit is on the line and which is captured next.
    always_comb begin
        ec_m1  = ec_q - EC_W'(1);
        ec_end = {len_q, 1'b0};
        k_smp  = ec_q[EC_W-1:1];
        if (mode_q.phase) begin
            k_out = (ec_q == '0) ? '0 : ec_m1[EC_W-1:1];
        end else begin
            k_out = ec_q[EC_W-1:1];
        end
        p_out   = phys_pos(k_out, len_q, rev_q);
        p_smp   = phys_pos(k_smp, len_q, rev_q);
        bit_out = 1'b0;
        for (int i = 0; i < MAX_LEN; i++) begin
            if (p_out == LEN_W'(i)) bit_out = tx_q[i];
        end
    end

    // Sequences idle, shifting and the done cycle; captures miso on sampling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            len_q   <= '0;
            cs_q    <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            ec_q    <= '0;
            tgl_q   <= 1'b0;
            rev_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        mode_q  <= mode_sel;
                        len_q   <= char_len;
                        cs_q    <= cs_sel;
                        tx_q    <= tx_data;
                        rx_q    <= '0;
                        ec_q    <= '0;
                        tgl_q   <= 1'b0;
                        rev_q   <= mode_sel.msb_first &&
                                   (char_len == LEN_W'(8) || char_len == LEN_W'(16));
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (ec_q < ec_end) begin
                            tgl_q <= ~tgl_q;
                            ec_q  <= ec_q + EC_W'(1);
                            if (ec_q[0] == mode_q.phase) begin
                                for (int i = 0; i < MAX_LEN; i++) begin
                                    if (p_smp == LEN_W'(i)) rx_q[i] <= miso;
                                end
                            end
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign running = (state_q == ST_RUN);
    assign sck     = mode_q.invert ^ tgl_q;
    assign mosi    = running && (k_out < len_q) ? bit_out : 1'b0;
    assign rx_data = rx_q;
    assign done    = (state_q == ST_DONE);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        // Drives one active-low select while its index owns the transfer.
        assign cs_n[g] = !(running && cs_q == CS_W'(g));
    end

    // R3: never more than one chip select low.
    p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R4: sck only moves on a tick while shifting.
    p_sck_paced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick) |=> $stable(sck));

    // R4: every transfer made exactly twice its length in edges.
    p_edge_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ec_q == ec_end));

    // R8: done only with all selects released, and lasting one cycle.
    p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&cs_n));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a start during a transfer leaves the selects alone unless a tick ends it.
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start && !tick) |=> $stable(cs_n));

endmodule

// File: rtl/spi_cs_master.sv
// Module: top of the per-chip-select SPI master. Joins the mode word bank
// to the shift engine; the engine reads the word addressed by cs_idx.
// Assumes: the baud tick comes from outside; lengths 4..16.
module spi_cs_master
    import spi_cs_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int MAX_LEN = 16,
    parameter int CS_W    = $clog2(NUM_CS),
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CS_W-1:0]    cfg_addr,
    input  logic [MODE_W-1:0]  cfg_wdata,
    output logic [MODE_W-1:0]  cfg_rdata,
    input  logic               start,
    input  logic [CS_W-1:0]    cs_idx,
    input  logic [MAX_LEN-1:0] tx_data,
    input  logic [LEN_W-1:0]   char_len,
    input  logic               tick,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic [NUM_CS-1:0]  cs_n,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               done
);

    spi_mode_t rd_mode;
    spi_mode_t sel_mode;

    spi_mode_bank #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_mode  (spi_mode_t'(cfg_wdata)),
        .rd_addr  (cfg_addr),
        .rd_mode  (rd_mode),
        .sel_addr (cs_idx),
        .sel_mode (sel_mode)
    );

    assign cfg_rdata = rd_mode;

    spi_shift_engine #(.NUM_CS(NUM_CS), .MAX_LEN(MAX_LEN), .CS_W(CS_W), .LEN_W(LEN_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cs_sel   (cs_idx),
        .mode_sel (sel_mode),
        .tx_data  (tx_data),
        .char_len (char_len),
        .tick     (tick),
        .miso     (miso),
        .sck      (sck),
        .mosi     (mosi),
        .cs_n     (cs_n),
        .rx_data  (rx_data),
        .done     (done)
    );

endmodule

// File: tb/spi_cs_master_tb.sv
// Bench: vector table of transfers walked by one loop, then directed tests
// for reset, mode independence, busy starts and mid-transfer mode writes.
module spi_cs_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [2:0]  cfg_wdata = '0;
    logic [2:0]  cfg_rdata;
    logic        start = 1'b0;
    logic [1:0]  cs_idx = '0;
    logic [15:0] tx_data = '0;
    logic [4:0]  char_len = 5'd8;
    logic        tick;
    logic        miso;
    logic        sck, mosi, done;
    logic [3:0]  cs_n;
    logic [15:0] rx_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spi_cs_master u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .start(start),
        .cs_idx(cs_idx), .tx_data(tx_data), .char_len(char_len), .tick(tick),
        .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n), .rx_data(rx_data),
        .done(done)
    );

    // Baud tick every third cycle.
    logic [1:0] tdiv = '0;
    always @(posedge clk) tdiv <= (!rst_n || tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
    assign tick = (tdiv == 2'd2);

    // Slave loopback: returns the inverse of what it hears.
    assign miso = ~mosi;

    // Monitor: counts sck toggles during a held select, records mosi on capturing toggles.
    logic        mon_phase = 1'b0;
    int          edge_cnt = 0;
    int          ncap = 0;
    int          stray = 0;
    logic [15:0] cap = '0;
    logic        prev_sck = 1'b0;
    logic        prev_act = 1'b0;
    always @(negedge clk) begin
        logic act;
        act = (cs_n != 4'hF);
        if (act && !prev_act) begin
            edge_cnt <= 0;
            ncap     <= 0;
            cap      <= '0;
        end else if (act && prev_act && sck != prev_sck) begin
            if ((edge_cnt % 2) == int'(mon_phase) && ncap < 16) begin
                cap[ncap] <= mosi;
                ncap      <= ncap + 1;
            end
            edge_cnt <= edge_cnt + 1;
        end
        if (!act && !prev_act && sck != prev_sck) stray <= stray + 1;
        prev_sck <= sck;
        prev_act <= act;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] lmask(input int len);
        return 16'((32'd1 << len) - 1);
    endfunction

    function automatic logic [15:0] order_of(input logic [15:0] tx, input int len, input bit rev);
        logic [15:0] o;
        o = '0;
        for (int i = 0; i < len; i++) o[i] = rev ? tx[len-1-i] : tx[i];
        return o;
    endfunction

    task automatic write_mode(input logic [1:0] a, input logic [2:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = m;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cfg_rdata == m, "R1 mode readback", int'(cfg_rdata), int'(m));
    endtask

    task automatic run_xfer(input logic [1:0] cs, input logic [2:0] mode, input int len,
                            input logic [15:0] tx, input bit poke_start, input bit poke_mode);
        bit rev;
        int cyc;
        logic [3:0] sel;
        rev = mode[2] && (len == 8 || len == 16);
        sel = ~(4'b0001 << cs);
        write_mode(cs, mode);
        mon_phase = mode[1];
        start = 1'b1; cs_idx = cs; tx_data = tx; char_len = 5'(len);
        @(negedge clk);
        start = 1'b0;
        chk(cs_n == sel, "R3 select asserted", int'(cs_n), int'(sel));
        chk(sck == mode[0], "R2 idle level captured", int'(sck), int'(mode[0]));
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 10) begin
                if (poke_start) begin
                    start = 1'b1; cs_idx = cs + 2'd1; tx_data = ~tx; char_len = 5'd4;
                end
                if (poke_mode) begin
                    cfg_we = 1'b1; cfg_addr = cs; cfg_wdata = ~mode;
                end
            end
            if (cyc == 11) begin
                start = 1'b0; cfg_we = 1'b0;
                if (poke_start) chk(cs_n == sel, "R9 busy start ignored", int'(cs_n), int'(sel));
                if (poke_mode) chk(cfg_rdata == ~mode, "R10 write lands in word", int'(cfg_rdata), int'(~mode));
            end
        end
        chk(done == 1'b1, "R8 done arrives", int'(done), 1);
        chk(cs_n == 4'hF, "R8 done with selects released", int'(cs_n), 15);
        chk(rx_data == (~tx & lmask(len)), "R7 received character", int'(rx_data), int'(~tx & lmask(len)));
        chk(cap == order_of(tx, len, rev), "R5 R6 capture order", int'(cap), int'(order_of(tx, len, rev)));
        chk(edge_cnt == 2 * len, "R4 toggle count", edge_cnt, 2 * len);
        chk(sck == mode[0], "R2 sck back at idle", int'(sck), int'(mode[0]));
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    endtask

    // Transfers: {cs[25:24], mode[23:21], len[20:16], tx[15:0]}.
    localparam logic [25:0] VEC [10] = '{
        {2'd0, 3'b000, 5'd8,  16'h00A5},
        {2'd1, 3'b001, 5'd8,  16'h003C},
        {2'd2, 3'b010, 5'd16, 16'h1234},
        {2'd3, 3'b111, 5'd16, 16'hC3A1},
        {2'd0, 3'b100, 5'd8,  16'h004D},
        {2'd1, 3'b101, 5'd12, 16'h0ABC},
        {2'd2, 3'b110, 5'd4,  16'h0006},
        {2'd3, 3'b011, 5'd5,  16'h0013},
        {2'd0, 3'b110, 5'd16, 16'h8E01},
        {2'd1, 3'b100, 5'd9,  16'h0133}
    };

    initial begin
        // Reset state.
        repeat (3) @(negedge clk);
        chk(cs_n == 4'hF, "R3 selects idle in reset", int'(cs_n), 15);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 4'hF, "R3 selects idle after reset", int'(cs_n), 15);
        chk(sck == 1'b0, "R2 sck low after reset", int'(sck), 0);
        chk(mosi == 1'b0, "R5 mosi quiet after reset", int'(mosi), 0);
        chk(done == 1'b0, "R8 no done after reset", int'(done), 0);
        for (int a = 0; a < 4; a++) begin
            cfg_addr = 2'(a);
            #1;
            chk(cfg_rdata == 3'b000, "R1 word zero after reset", int'(cfg_rdata), 0);
        end

        // Table of transfers.
        for (int v = 0; v < 10; v++) begin
            run_xfer(VEC[v][25:24], VEC[v][23:21], int'(VEC[v][20:16]), VEC[v][15:0], 1'b0, 1'b0);
        end

        // R1: four distinct words are held independently.
        write_mode(2'd0, 3'b001);
        write_mode(2'd1, 3'b010);
        write_mode(2'd2, 3'b100);
        write_mode(2'd3, 3'b111);
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            cfg_addr = 2'(a);
            #1;
            chk(cfg_rdata == 3'((a == 0) ? 1 : (a == 1) ? 2 : (a == 2) ? 4 : 7),
                "R1 independent words", int'(cfg_rdata),
                (a == 0) ? 1 : (a == 1) ? 2 : (a == 2) ? 4 : 7);
        end

        // R9: start while busy is ignored.
        run_xfer(2'd2, 3'b010, 16, 16'hB00F, 1'b1, 1'b0);
        run_xfer(2'd0, 3'b100, 8, 16'h00F1, 1'b1, 1'b0);

        // R10: mode write mid-transfer does not alter the running transfer.
        run_xfer(2'd1, 3'b001, 8, 16'h0096, 1'b0, 1'b1);
        run_xfer(2'd3, 3'b110, 16, 16'h5A0F, 1'b0, 1'b1);

        // R6: MSB-first request at length 7 falls back to LSB first.
        run_xfer(2'd2, 3'b100, 7, 16'h0041, 1'b0, 1'b0);

        // R2: no toggles while idle over the whole run.
        chk(stray == 0, "R2 no idle toggles", stray, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule